// File: doc/BRIEF.md
# Single-Cycle Program Counter Sequencer

This block chooses the next instruction fetch address for a small 8-bit accumulator controller with a 14-bit instruction word and a 13-bit program space. Program memory is synchronous. The sequencer looks at the instruction word that memory returned after the last clock edge. In the same cycle, with no register stage, it drives the address of the instruction to fetch next. Because of this, unconditional jumps, subroutine calls and all return forms complete in one clock. The target goes straight onto the address bus.

The block also keeps the following state:
- A 16-entry circular return stack. A separate unit computes its next stack pointer.
- A one-cycle squash flag. It cancels the instruction that follows a taken skip, so a taken skip costs exactly one idle clock.
- A global interrupt enable. An accepted interrupt request clears it, and the return-from-interrupt instruction sets it again.

The datapath supplies three things. It raises the skip condition for a bit test whose outcome is taken. It supplies the 5-bit upper-address latch. It drives the low-byte write port when an instruction writes the low program-counter byte (a computed jump).

Top module: `pc_sequencer`

## Requirements
- R1: While reset is high, the fetch address is 0x000. The first clock edge with reset high empties the return stack, clears the squash flag and sets the interrupt enable to its parameter value (default 1). The instruction seen after reset is the one at address 0x000.
- R2: An ordinary instruction gives a fetch address of current address plus one in the same cycle, wrapping from 0x1FFF to 0x000.
- R3: A jump (bits [13:11] = 101) gives a fetch address of {latch[4:3], instruction[10:0]} in the same cycle, with no stack change.
- R4: A call (bits [13:11] = 100) gives the same target form as a jump, and pushes current address plus one onto the return stack.
- R5: A return (0x0008) or return-with-literal (bits [13:10] = 1101) gives the most recently pushed address as the fetch address in the same cycle, and pops it.
- R6: When the skip condition is high during a valid instruction, the squash output is high for exactly the next cycle. During that cycle the instruction is treated as a no-operation: the fetch address is current plus one, and its jump, call, return, low-byte write, skip condition and interrupt acceptance all have no effect.
- R7: A valid ordinary instruction with the low-byte write high gives a fetch address of {latch[4:0], write data[7:0]}.
- R8: The stack pointer wraps modulo 16 without an error. Seventeen calls overwrite the oldest entry, and later returns read entries in circular last-in-first-out order.
- R9: An interrupt request is accepted only when all of the following hold: interrupts are enabled, and the current instruction is valid, ordinary, and has no skip condition and no low-byte write. On acceptance the fetch address is 0x004, current plus one is pushed, and the enable drops on the next cycle. In any other cycle the request waits.
- R10: Return-from-interrupt (0x0009) pops like a return, and the interrupt enable reads 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 14 | Instruction word returned by program memory |
| skip_req | input | 1 | Taken skip condition for the current instruction |
| addr_latch | input | 5 | Upper program-address latch register |
| pcl_we | input | 1 | Current instruction writes the low program-counter byte |
| pcl_wdata | input | 8 | Data for the low-byte write |
| irq | input | 1 | Interrupt request level |
| fetch_addr | output | 13 | Combinational next fetch address to program memory |
| squash | output | 1 | Current instruction is cancelled by a taken skip |
| irq_en | output | 1 | Global interrupt enable |

## Verification
The assertions check the following on every cycle:
- the reset address;
- that squash never lasts two cycles, and that during a squash the fetch address advances by one;
- that the jump literal appears in the low address bits;
- that ordinary no-operation flow gives plus one;
- that every drop of the interrupt enable coincides with a vector fetch;
- that every rise of the enable follows an unsquashed return-from-interrupt.

Some behaviour only the bench scenarios can show, because they depend on contents built up over many cycles:
- the stack order across deep nesting and modulo-16 wrap;
- the addresses that returns deliver;
- the deferral of an interrupt request across squashed and control-flow cycles.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_GOTO  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETIE = 3'd4
  } op_e;

  // Classify a 14-bit instruction word into a flow class
  function automatic op_e classify(input logic [13:0] w);
    op_e r;
    if (w == 14'h0008)               r = OP_RET;
    else if (w == 14'h0009)          r = OP_RETIE;
    else if (w[13:10] == 4'b1101)    r = OP_RET;
    else if (w[13:11] == 3'b100)     r = OP_CALL;
    else if (w[13:11] == 3'b101)     r = OP_GOTO;
    else                             r = OP_SEQ;
    return r;
  endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode #(
  parameter int INSTR_W = 14,
  parameter int JMP_W   = 11
) (
  input  logic [INSTR_W-1:0] instr,
  output pcseq_pkg::op_e     op,
  output logic [JMP_W-1:0]   lit
);
  always_comb begin
    op  = pcseq_pkg::classify(instr);
    lit = instr[JMP_W-1:0];
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top_data
);
  localparam int SP_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_nxt;
  logic [SP_W-1:0]   rd_idx;

  // next stack pointer unit: wraps modulo DEPTH
  always_comb begin
    sp_nxt = sp_q;
    if (push)     sp_nxt = sp_q + SP_W'(1);
    else if (pop) sp_nxt = sp_q - SP_W'(1);
  end

  assign rd_idx   = sp_q - SP_W'(1);
  assign top_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) sp_q <= '0;
    else     sp_q <= sp_nxt;
  end

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push && !rst) mem[sp_q] <= push_data;
  end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next #(
  parameter int              ADDR_W  = 13,
  parameter int              JMP_W   = 11,
  parameter logic [ADDR_W-1:0] VECTOR = 13'h004
) (
  input  logic                rst,
  input  logic                valid,
  input  pcseq_pkg::op_e      op,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [JMP_W-1:0]    lit,
  input  logic [ADDR_W-9:0]   latch,
  input  logic                pcl_we,
  input  logic [7:0]          pcl_wdata,
  input  logic                irq_take,
  input  logic [ADDR_W-1:0]   stk_top,
  output logic [ADDR_W-1:0]   nxt
);
  localparam int LATCH_W = ADDR_W - 8;
  localparam int HI_W    = ADDR_W - JMP_W;

  logic [ADDR_W-1:0] pc_inc;
  assign pc_inc = pc + ADDR_W'(1);

  always_comb begin
    if (rst)         nxt = '0;
    else if (!valid) nxt = pc_inc;
    else begin
      unique case (op)
        pcseq_pkg::OP_RET,
        pcseq_pkg::OP_RETIE: nxt = stk_top;
        pcseq_pkg::OP_GOTO,
        pcseq_pkg::OP_CALL:  nxt = {latch[LATCH_W-1 -: HI_W], lit};
        default: begin
          if (pcl_we)        nxt = {latch, pcl_wdata};
          else if (irq_take) nxt = VECTOR;
          else               nxt = pc_inc;
        end
      endcase
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int                ADDR_W      = 13,
  parameter int                INSTR_W     = 14,
  parameter int                JMP_W       = 11,
  parameter int                STACK_DEPTH = 16,
  parameter logic [ADDR_W-1:0] VECTOR      = 13'h004,
  parameter logic              IRQ_EN_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               skip_req,
  input  logic [ADDR_W-9:0]  addr_latch,
  input  logic               pcl_we,
  input  logic [7:0]         pcl_wdata,
  input  logic               irq,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               squash,
  output logic               irq_en
);
  pcseq_pkg::op_e    op;
  logic [JMP_W-1:0]  lit;
  logic [ADDR_W-1:0] pc_q;
  logic              squash_q;
  logic              gie_q;
  logic              valid;
  logic              is_pop;
  logic              is_push;
  logic              irq_take;
  logic [ADDR_W-1:0] stk_top;
  logic [ADDR_W-1:0] ret_addr;

  pcseq_decode #(.INSTR_W(INSTR_W), .JMP_W(JMP_W)) u_dec (
    .instr(instr), .op(op), .lit(lit)
  );

  always_comb begin
    valid    = !squash_q;
    is_pop   = !rst && valid &&
               (op == pcseq_pkg::OP_RET || op == pcseq_pkg::OP_RETIE);
    irq_take = !rst && valid && op == pcseq_pkg::OP_SEQ && !pcl_we &&
               !skip_req && irq && gie_q;
    is_push  = !rst && valid && (op == pcseq_pkg::OP_CALL || irq_take);
    ret_addr = pc_q + ADDR_W'(1);
  end

  pcseq_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(is_push), .pop(is_pop),
    .push_data(ret_addr), .top_data(stk_top)
  );

  pcseq_next #(.ADDR_W(ADDR_W), .JMP_W(JMP_W), .VECTOR(VECTOR)) u_nxt (
    .rst(rst), .valid(valid), .op(op), .pc(pc_q), .lit(lit),
    .latch(addr_latch), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
    .irq_take(irq_take), .stk_top(stk_top), .nxt(fetch_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      squash_q <= 1'b0;
      gie_q    <= IRQ_EN_INIT;
    end else begin
      pc_q     <= fetch_addr;
      squash_q <= valid && skip_req;
      if (valid && op == pcseq_pkg::OP_RETIE) gie_q <= 1'b1;
      else if (irq_take)                      gie_q <= 1'b0;
    end
  end

  assign squash = squash_q;
  assign irq_en = gie_q;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int                ADDR_W  = 13,
  parameter int                INSTR_W = 14,
  parameter int                JMP_W   = 11,
  parameter logic [ADDR_W-1:0] VECTOR  = 13'h004
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic               pcl_we,
  input logic               irq,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               squash,
  input logic               irq_en,
  input logic [ADDR_W-1:0]  pc
);
  // R1
  reset_addr_chk: assert property (@(posedge clk) rst |-> fetch_addr == '0);

  // R6
  squash_once_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> !squash);

  // R6
  squash_advance_chk: assert property (@(posedge clk) disable iff (rst)
    squash |-> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  // R3
  jump_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (!squash && instr[INSTR_W-1 -: 3] == 3'b101)
      |-> fetch_addr[JMP_W-1:0] == instr[JMP_W-1:0]);

  // R2
  seq_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (!squash && instr == '0 && !pcl_we && !(irq && irq_en))
      |-> fetch_addr == pc + ADDR_W'(1));

  // R9
  irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_en) |-> $past(fetch_addr) == VECTOR);

  // R10
  retie_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_en) |-> ($past(instr) == INSTR_W'(14'h0009) && !$past(squash)));
endmodule

bind pc_sequencer pcseq_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .JMP_W(JMP_W), .VECTOR(VECTOR)
) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pcl_we(pcl_we), .irq(irq),
  .fetch_addr(fetch_addr), .squash(squash), .irq_en(irq_en), .pc(pc_q)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] instr = '0;
  logic        skip_req = 1'b0;
  logic [4:0]  addr_latch = '0;
  logic        pcl_we = 1'b0;
  logic [7:0]  pcl_wdata = '0;
  logic        irq = 1'b0;
  logic [12:0] fetch_addr;
  logic        squash;
  logic        irq_en;

  int checks = 0;
  int errors = 0;

  logic [12:0] m_pc;
  logic [3:0]  m_sp;
  logic [12:0] m_stk [16];
  logic        m_sq;
  logic        m_gie;

  always #10 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .instr(instr), .skip_req(skip_req),
    .addr_latch(addr_latch), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
    .irq(irq), .fetch_addr(fetch_addr), .squash(squash), .irq_en(irq_en)
  );

  task automatic check(input string tag, input string what,
                       input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [13:0] w);
    if (w == 14'h0009)             return "R10";
    if (w == 14'h0008)             return "R5";
    if (w[13:10] == 4'b1101)       return "R5";
    if (w[13:11] == 3'b100)        return "R4";
    if (w[13:11] == 3'b101)        return "R3";
    return "R2";
  endfunction

  // one clock: drive at falling edge, compare, then advance the model
  task automatic step(input logic [13:0] w, input logic sk, input logic we,
                      input logic [7:0] wd, input logic [4:0] lat,
                      input logic ir, input string tag_in);
    logic [12:0] exp;
    logic [12:0] inc;
    string       tag;
    @(negedge clk);
    instr = w; skip_req = sk; pcl_we = we; pcl_wdata = wd;
    addr_latch = lat; irq = ir; rst = 1'b0;
    #2;
    tag = (tag_in == "") ? tag_of(w) : tag_in;
    check("R6", "squash", {12'd0, squash}, {12'd0, m_sq});
    check("R9", "irq_en", {12'd0, irq_en}, {12'd0, m_gie});
    inc = m_pc + 13'd1;
    if (m_sq) begin
      exp = inc;
      tag = "R6";
    end else if (w == 14'h0008 || w == 14'h0009 || w[13:10] == 4'b1101) begin
      m_sp = m_sp - 4'd1;
      exp  = m_stk[m_sp];
      if (w == 14'h0009) m_gie = 1'b1;
    end else if (w[13:12] == 2'b10) begin
      exp = {lat[4:3], w[10:0]};
      if (!w[11]) begin m_stk[m_sp] = inc; m_sp = m_sp + 4'd1; end
    end else if (we) begin
      exp = {lat, wd};
      tag = "R7";
    end else if (ir && m_gie && !sk) begin
      exp = 13'h004;
      m_stk[m_sp] = inc; m_sp = m_sp + 4'd1;
      m_gie = 1'b0;
      tag = "R9";
    end else begin
      exp = inc;
    end
    check(tag, "fetch_addr", fetch_addr, exp);
    m_sq = !m_sq && sk;
    m_pc = exp;
  endtask

  localparam logic [13:0] NOP    = 14'h0000;
  localparam logic [13:0] RET    = 14'h0008;
  localparam logic [13:0] RETIE  = 14'h0009;

  function automatic logic [13:0] goto_of(input logic [10:0] k);
    return {3'b101, k};
  endfunction
  function automatic logic [13:0] call_of(input logic [10:0] k);
    return {3'b100, k};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired, no requirement completed");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds address at zero
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rst = 1'b1; instr = call_of(11'h155); irq = 1'b1;
      #2 check("R1", "fetch_addr in reset", fetch_addr, 13'h000);
    end
    m_pc = '0; m_sp = '0; m_sq = 1'b0; m_gie = 1'b1;
    for (int i = 0; i < 16; i++) m_stk[i] = '0;

    // R2 ordinary flow, R3 jump with latch bits, wrap at top
    step(NOP, 0, 0, 8'h00, 5'h00, 0, "R1");
    step(NOP, 0, 0, 8'h00, 5'h00, 0, "R2");
    step(goto_of(11'h7FF), 0, 0, 8'h00, 5'b11000, 0, "R3");
    step(NOP, 0, 0, 8'h00, 5'h00, 0, "R2");
    // R4 call then R5 return and return-with-literal
    step(14'h2018, 0, 0, 8'h00, 5'h00, 0, "R4");
    step(call_of(11'h321), 0, 0, 8'h00, 5'b01000, 0, "R4");
    step({4'b1101, 2'b00, 8'hA5}, 0, 0, 8'h00, 5'h00, 0, "R5");
    step(RET, 0, 0, 8'h00, 5'h00, 0, "R5");
    // R7 low-byte write
    step(14'h0182, 0, 1, 8'h3C, 5'b10110, 0, "R7");
    // R6 skip: squashed jump, skip and write have no effect
    step(NOP, 1, 0, 8'h00, 5'h00, 0, "R6");
    step(goto_of(11'h100), 1, 1, 8'h77, 5'h1F, 1, "R6");
    step(NOP, 0, 0, 8'h00, 5'h00, 0, "R6");
    // R9 deferral across squash and jump, then acceptance
    step(NOP, 1, 0, 8'h00, 5'h00, 1, "R9");
    step(NOP, 0, 0, 8'h00, 5'h00, 1, "R9");
    step(goto_of(11'h040), 0, 0, 8'h00, 5'h00, 1, "R9");
    step(NOP, 0, 0, 8'h00, 5'h00, 1, "R9");
    step(NOP, 0, 0, 8'h00, 5'h00, 1, "R9");
    // R10 return from interrupt restores enable
    step(RETIE, 0, 0, 8'h00, 5'h00, 0, "R10");
    step(NOP, 0, 0, 8'h00, 5'h00, 0, "R10");
    // R8 seventeen calls then seventeen returns wrap the stack
    for (int i = 0; i < 17; i++)
      step(call_of(11'(i * 16 + 5)), 0, 0, 8'h00, 5'h00, 0, "R8");
    for (int i = 0; i < 17; i++)
      step(RET, 0, 0, 8'h00, 5'h00, 0, "R8");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [13:0] w;
      logic sk, we;
      r  = $urandom % 16;
      sk = 1'b0; we = 1'b0;
      w  = {6'b000111, 8'($urandom)};
      if (r == 6 || r == 7)        w = goto_of(11'($urandom));
      else if (r == 8 || r == 9)   w = call_of(11'($urandom));
      else if (r == 10)            w = RET;
      else if (r == 11)            w = {4'b1101, 2'b10, 8'($urandom)};
      else if (r == 12)            w = RETIE;
      else if (r == 13)            we = 1'b1;
      else if (r >= 14)            sk = 1'b1;
      step(w, sk, we, 8'($urandom), 5'($urandom),
           ($urandom % 4) == 0, "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule